// File: doc/BRIEF.md
# Replicated Register Bank with Steered Access

This block holds a small set of configuration registers. Each hardware unit has its own copy of each register, and all copies of one register answer at a single bus offset. A steering selector register sits on the same bus. It names a target unit by a group ID and an instance ID, and it carries a broadcast flag. When the flag is set, a write reaches every reachable copy. When the flag is clear, a write reaches only the copy of the target unit. A read always returns the copy of the target unit, whatever the state of the flag.

Each unit may be fused off or power-gated, and two 16-bit mask inputs report this, with one bit per unit. The unit index is `group * 4 + instance`. An access aimed at an unavailable unit is terminated without error. A read of that unit returns zero, and a write to it changes nothing. Software normally saves the selector, points it at a unit, performs the access, and then writes the saved value back.

The bus is a simple single-cycle port with no wait states. Read data is registered and is returned one cycle after the request.

Top module: `rrb_bank`

## Requirements
- R1: After reset, the selector reads `0x8000_0000` (broadcast flag set, both IDs zero) and every register copy reads zero.
- R2: The selector keeps the broadcast flag in bit 31, the group ID in bits [11:8] and the instance ID in bits [3:0]. All other bits read as zero.
- R3: With the broadcast flag set, a write to a replicated register updates every copy of that register whose unit is available.
- R4: With the broadcast flag clear, a write updates only the copy of the unit chosen by group and instance. Other units and other registers keep their values.
- R5: A read returns the selected unit's copy whether the broadcast flag is set or clear, and a read never changes any copy.
- R6: A read aimed at a unit whose fuse-disable bit or power-gate bit is set returns zero. The stored copy is kept and becomes readable again once the unit is available.
- R7: A targeted write aimed at a fused-off or power-gated unit is dropped.
- R8: A broadcast write leaves unchanged the copies of units that are unavailable at the time of the write.
- R9: A group ID of 4 or above, or an instance ID of 4 or above, names no unit. A read then returns zero and a targeted write is dropped.
- R10: A read of an unmapped word address returns zero, and a write to one changes no copy.
- R11: Read data and `bus_rvalid` appear in the cycle after a read request. `bus_rvalid` is high only in that cycle.
- R12: The selector is at word address 0, and replicated register k (0 to 3) is at word address 4+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| fuse_dis | input | 16 | Per-unit fuse-disable mask, bit index = group*4+instance |
| pwr_gate | input | 16 | Per-unit power-gate mask, same indexing |

## Verification
A write takes effect at the clock edge that samples it, so its result can be seen by a read issued in the very next cycle. A read's data and valid strobe become valid one edge after the request. Each bench task drives a request on a falling edge and samples on the next falling edge, which lies half a cycle after the edge that produced the result. The latency scenario also checks that the strobe is low during the request cycle and low again in the cycle after the return.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    localparam int BUS_W        = 32;
    localparam int ID_W         = 4;
    localparam int SEL_MC_BIT   = 31;
    localparam int SEL_GRP_LSB  = 8;
    localparam int SEL_INST_LSB = 0;

    typedef struct packed {
        logic            mcast;
        logic [ID_W-1:0] grp;
        logic [ID_W-1:0] inst;
    } steer_t;

    localparam steer_t STEER_RST = '{mcast: 1'b1, grp: '0, inst: '0};

    function automatic logic [BUS_W-1:0] steer_pack(steer_t s);
        logic [BUS_W-1:0] w;
        w = '0;
        w[SEL_MC_BIT]                = s.mcast;
        w[SEL_GRP_LSB +: ID_W]       = s.grp;
        w[SEL_INST_LSB +: ID_W]      = s.inst;
        return w;
    endfunction

    function automatic steer_t steer_unpack(logic [BUS_W-1:0] w);
        steer_t s;
        s.mcast = w[SEL_MC_BIT];
        s.grp   = w[SEL_GRP_LSB +: ID_W];
        s.inst  = w[SEL_INST_LSB +: ID_W];
        return s;
    endfunction

endpackage

// File: rtl/rrb_steer_sel.sv
module rrb_steer_sel
    import rrb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  steer_t wr_val,
    output steer_t sel_q
);

    steer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STEER_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q;

endmodule

// File: rtl/rrb_addr_decode.sv
module rrb_addr_decode #(
    parameter  int ADDR_W    = 8,
    parameter  int NUM_REGS  = 4,
    parameter  int REG_BASE  = 4,
    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit_sel,
    output logic                 hit_reg,
    output logic [REG_IDX_W-1:0] reg_idx
);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off     = addr - ADDR_W'(REG_BASE);
        hit_sel = (addr == '0);
        hit_reg = (addr >= ADDR_W'(REG_BASE)) && (off < ADDR_W'(NUM_REGS));
        reg_idx = off[REG_IDX_W-1:0];
    end

endmodule

// File: rtl/rrb_copy_store.sv
module rrb_copy_store
    import rrb_pkg::*;
#(
    parameter  int NUM_UNITS = 16,
    parameter  int NUM_REGS  = 4,
    localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int FLAT_W    = NUM_UNITS * NUM_REGS * BUS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] wr_reg,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic [NUM_UNITS-1:0] unit_wmask,
    input  logic [UNIT_W-1:0]    rd_unit,
    input  logic [REG_IDX_W-1:0] rd_reg,
    output logic [BUS_W-1:0]     rd_data,
    output logic [FLAT_W-1:0]    copies_flat
);

    typedef logic [NUM_REGS-1:0][BUS_W-1:0] unit_regs_t;

    unit_regs_t bank [NUM_UNITS];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_regs_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (wr_en && unit_wmask[u]) begin
                st_d[wr_reg] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign bank[u] = st_q;
        assign copies_flat[u*NUM_REGS*BUS_W +: NUM_REGS*BUS_W] = st_q;
    end

    always_comb begin
        rd_data = bank[rd_unit][rd_reg];
    end

endmodule

// File: rtl/rrb_bank.sv
module rrb_bank
    import rrb_pkg::*;
#(
    parameter  int NUM_GROUPS = 4,
    parameter  int NUM_INST   = 4,
    parameter  int NUM_REGS   = 4,
    parameter  int ADDR_W     = 8,
    parameter  int REG_BASE   = 4,
    localparam int NUM_UNITS  = NUM_GROUPS * NUM_INST
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_UNITS-1:0] fuse_dis,
    input  logic [NUM_UNITS-1:0] pwr_gate
);

    localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
    localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int FLAT_W    = NUM_UNITS * NUM_REGS * BUS_W;

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    logic                 hit_sel, hit_reg;
    logic [REG_IDX_W-1:0] reg_idx;
    steer_t               sel_q;
    logic                 sel_wr;
    logic                 tgt_ok, tgt_live;
    logic [UNIT_W-1:0]    tgt_unit;
    logic [NUM_UNITS-1:0] unavail;
    logic [NUM_UNITS-1:0] wmask;
    logic                 copy_wr;
    logic [BUS_W-1:0]     copy_rd;
    logic [FLAT_W-1:0]    copies_flat;

    rrb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .REG_BASE (REG_BASE)
    ) u_dec (
        .addr    (bus_addr),
        .hit_sel (hit_sel),
        .hit_reg (hit_reg),
        .reg_idx (reg_idx)
    );

    rrb_steer_sel u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sel_wr),
        .wr_val (steer_unpack(bus_wdata)),
        .sel_q  (sel_q)
    );

    rrb_copy_store #(
        .NUM_UNITS (NUM_UNITS),
        .NUM_REGS  (NUM_REGS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (copy_wr),
        .wr_reg      (reg_idx),
        .wr_data     (bus_wdata),
        .unit_wmask  (wmask),
        .rd_unit     (tgt_unit),
        .rd_reg      (reg_idx),
        .rd_data     (copy_rd),
        .copies_flat (copies_flat)
    );

    // Steering target resolution and write fan-out
    always_comb begin
        unavail  = fuse_dis | pwr_gate;
        tgt_ok   = (int'(sel_q.grp) < NUM_GROUPS) && (int'(sel_q.inst) < NUM_INST);
        tgt_unit = tgt_ok ? UNIT_W'(int'(sel_q.grp) * NUM_INST + int'(sel_q.inst)) : '0;
        tgt_live = tgt_ok && !unavail[tgt_unit];

        sel_wr  = bus_en && bus_we && hit_sel;
        copy_wr = bus_en && bus_we && hit_reg;

        wmask = '0;
        if (sel_q.mcast) begin
            wmask = ~unavail;
        end else if (tgt_live) begin
            wmask[tgt_unit] = 1'b1;
        end
    end

    // Registered read return
    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = bus_en && !bus_we;
        if (bus_en && !bus_we) begin
            if (hit_sel) begin
                rd_d.data = steer_pack(sel_q);
            end else if (hit_reg && tgt_live) begin
                rd_d.data = copy_rd;
            end else begin
                rd_d.data = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata  = rd_q.data;
    assign bus_rvalid = rd_q.valid;

endmodule

// File: rtl/rrb_bank_chk.sv
module rrb_bank_chk
    import rrb_pkg::*;
#(
    parameter  int NUM_GROUPS = 4,
    parameter  int NUM_INST   = 4,
    parameter  int NUM_REGS   = 4,
    parameter  int ADDR_W     = 8,
    parameter  int REG_BASE   = 4,
    localparam int NUM_UNITS  = NUM_GROUPS * NUM_INST,
    localparam int UNIT_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int FLAT_W     = NUM_UNITS * NUM_REGS * BUS_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_en,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic                 bus_rvalid,
    input logic [NUM_UNITS-1:0] fuse_dis,
    input logic [NUM_UNITS-1:0] pwr_gate,
    input steer_t               sel,
    input logic [FLAT_W-1:0]    copies
);

    localparam logic [BUS_W-1:0] SEL_FIELDS =
        steer_pack('{mcast: 1'b1, grp: '1, inst: '1});

    logic rd_acc, wr_acc, is_sel, is_reg, unmapped, live;
    logic [NUM_UNITS-1:0] dead;

    always_comb begin
        rd_acc   = bus_en && !bus_we;
        wr_acc   = bus_en && bus_we;
        is_sel   = (int'(bus_addr) == 0);
        is_reg   = (int'(bus_addr) >= REG_BASE) && (int'(bus_addr) < REG_BASE + NUM_REGS);
        unmapped = !is_sel && !is_reg;
        dead     = fuse_dis | pwr_gate;
        live     = 1'b0;
        if ((int'(sel.grp) < NUM_GROUPS) && (int'(sel.inst) < NUM_INST)) begin
            live = !dead[UNIT_W'(int'(sel.grp) * NUM_INST + int'(sel.inst))];
        end
    end

    AST_READ_RETURNS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);                                        // R11
    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_acc));                                 // R11
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && unmapped) |=> (bus_rdata == '0));                   // R10
    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && unmapped) |=> $stable(copies));                     // R10
    AST_SEL_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && is_sel) |=> ((bus_rdata & ~SEL_FIELDS) == '0));     // R2
    AST_TERMINATED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && is_reg && !live) |=> (bus_rdata == '0));            // R6
    AST_READ_KEEPS_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(copies));                                  // R5

endmodule

bind rrb_bank rrb_bank_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_INST   (NUM_INST),
    .NUM_REGS   (NUM_REGS),
    .ADDR_W     (ADDR_W),
    .REG_BASE   (REG_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .fuse_dis   (fuse_dis),
    .pwr_gate   (pwr_gate),
    .sel        (sel_q),
    .copies     (copies_flat)
);

// File: tb/rrb_bank_tb_top.sv
`timescale 1ns/1ps
module rrb_bank_tb_top;

    localparam real CLK_PER = 4.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] fuse_dis, pwr_gate;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] model [16][4];
    logic        m_mc;
    logic [3:0]  m_grp, m_inst;

    always #(CLK_PER/2) clk = ~clk;

    rrb_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .fuse_dis   (fuse_dis),
        .pwr_gate   (pwr_gate)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int k);
        int u;
        if (m_grp >= 4 || m_inst >= 4) return 32'h0;
        u = int'(m_grp) * 4 + int'(m_inst);
        if (fuse_dis[u] || pwr_gate[u]) return 32'h0;
        return model[u][k];
    endfunction

    task automatic model_write(input int k, input logic [31:0] d);
        int tu;
        if (m_mc) begin
            for (int u = 0; u < 16; u++)
                if (!fuse_dis[u] && !pwr_gate[u]) model[u][k] = d;
        end else if (m_grp < 4 && m_inst < 4) begin
            tu = int'(m_grp) * 4 + int'(m_inst);
            if (!fuse_dis[tu] && !pwr_gate[tu]) model[tu][k] = d;
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        if (a == 8'd0) begin
            m_mc = d[31]; m_grp = d[11:8]; m_inst = d[3:0];
        end else if (a >= 8'd4 && a < 8'd8) begin
            model_write(int'(a) - 4, d);
        end
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
        check("R11 rvalid with read data", {31'b0, bus_rvalid}, 32'h1);
    endtask

    task automatic set_sel(input logic mc, input logic [3:0] g, input logic [3:0] i);
        bus_wr(8'd0, {mc, 19'b0, g, 4'b0, i});
    endtask

    task automatic rd_reg(input int k, input string tag);
        logic [31:0] d;
        bus_rd(8'(4 + k), d);
        check(tag, d, exp_read(k));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_rd(8'd0, d);
        check("R1 selector reset value", d, 32'h8000_0000);
        for (int k = 0; k < 4; k++) begin
            bus_rd(8'(4 + k), d);
            check("R1 copy reset zero", d, 32'h0);
        end
    endtask

    task automatic t_sel_layout;
        logic [31:0] d;
        bus_wr(8'd0, 32'hFFFF_FFFF);
        bus_rd(8'd0, d);
        check("R2 selector field layout", d, 32'h8000_0F0F);
        bus_wr(8'd0, 32'h0000_0302);
        bus_rd(8'd0, d);
        check("R2 selector fields cleared flag", d, 32'h0000_0302);
        set_sel(1'b1, 4'd0, 4'd0);
    endtask

    task automatic t_mcast;
        set_sel(1'b1, 4'd0, 4'd0);
        bus_wr(8'd5, 32'hA5A5_0001);
        for (int u = 0; u < 16; u += 5) begin
            set_sel(1'b0, 4'(u / 4), 4'(u % 4));
            rd_reg(1, "R3 broadcast reached unit");
        end
        set_sel(1'b0, 4'd3, 4'd3);
        rd_reg(1, "R3 broadcast reached last unit");
    endtask

    task automatic t_unicast;
        set_sel(1'b0, 4'd2, 4'd3);
        bus_wr(8'd6, 32'h0000_1234);
        rd_reg(2, "R4 targeted copy updated");
        set_sel(1'b0, 4'd2, 4'd2);
        rd_reg(2, "R4 neighbour copy untouched");
        set_sel(1'b1, 4'd2, 4'd3);
        rd_reg(2, "R5 read steered with flag set");
        rd_reg(1, "R4 other register untouched");
        // R12: distinct values at word addresses 4..7 for one unit
        set_sel(1'b0, 4'd3, 4'd0);
        for (int k = 0; k < 4; k++) bus_wr(8'(4 + k), 32'hC0DE_0000 + k);
        for (int k = 0; k < 4; k++) rd_reg(k, "R12 register address map");
    endtask

    task automatic t_term_read;
        set_sel(1'b0, 4'd2, 4'd3);
        @(negedge clk); fuse_dis = 16'h0800;
        rd_reg(2, "R6 fused unit reads zero");
        check("R6 fused read value", exp_read(2), 32'h0);
        @(negedge clk); fuse_dis = 16'h0; pwr_gate = 16'h0800;
        rd_reg(2, "R6 gated unit reads zero");
        @(negedge clk); pwr_gate = 16'h0;
        rd_reg(2, "R6 copy kept while unavailable");
    endtask

    task automatic t_term_write;
        set_sel(1'b0, 4'd1, 4'd1);
        @(negedge clk); pwr_gate = 16'h0020;
        bus_wr(8'd4, 32'h0000_DEAD);
        @(negedge clk); pwr_gate = 16'h0;
        rd_reg(0, "R7 gated targeted write dropped");
        @(negedge clk); fuse_dis = 16'h0020;
        bus_wr(8'd4, 32'h0000_BEEF);
        @(negedge clk); fuse_dis = 16'h0;
        rd_reg(0, "R7 fused targeted write dropped");
    endtask

    task automatic t_mcast_skip;
        set_sel(1'b1, 4'd0, 4'd0);
        @(negedge clk); fuse_dis = 16'h0001; pwr_gate = 16'h0100;
        bus_wr(8'd7, 32'h0000_0077);
        @(negedge clk); fuse_dis = 16'h0; pwr_gate = 16'h0;
        set_sel(1'b0, 4'd0, 4'd0);
        rd_reg(3, "R8 fused unit skipped by broadcast");
        set_sel(1'b0, 4'd2, 4'd0);
        rd_reg(3, "R8 gated unit skipped by broadcast");
        set_sel(1'b0, 4'd3, 4'd3);
        rd_reg(3, "R8 available unit written by broadcast");
    endtask

    task automatic t_out_of_range;
        set_sel(1'b0, 4'd5, 4'd0);
        bus_wr(8'd4, 32'h0000_0099);
        rd_reg(0, "R9 group out of range reads zero");
        set_sel(1'b0, 4'd1, 4'd7);
        bus_wr(8'd4, 32'h0000_0098);
        rd_reg(0, "R9 instance out of range reads zero");
        for (int u = 0; u < 16; u += 3) begin
            set_sel(1'b0, 4'(u / 4), 4'(u % 4));
            rd_reg(0, "R9 out-of-range write dropped");
        end
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        set_sel(1'b0, 4'd3, 4'd3);
        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_wr(8'd2, 32'hFFFF_FFFF);
        bus_rd(8'h20, d);
        check("R10 unmapped read zero", d, 32'h0);
        bus_rd(8'd3, d);
        check("R10 gap below registers reads zero", d, 32'h0);
        bus_rd(8'd8, d);
        check("R10 address past registers reads zero", d, 32'h0);
        for (int k = 0; k < 4; k++) rd_reg(k, "R10 unmapped write ignored");
    endtask

    task automatic t_latency;
        logic [31:0] d;
        set_sel(1'b0, 4'd3, 4'd0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'd5;
        #1;
        check("R11 no rvalid in request cycle", {31'b0, bus_rvalid}, 32'h0);
        @(negedge clk);
        bus_en = 1'b0;
        check("R11 rvalid one cycle after", {31'b0, bus_rvalid}, 32'h1);
        check("R11 data one cycle after", bus_rdata, exp_read(1));
        @(negedge clk);
        check("R11 rvalid drops after return", {31'b0, bus_rvalid}, 32'h0);
        bus_wr(8'd5, 32'h1);
        check("R11 no rvalid after write", {31'b0, bus_rvalid}, 32'h0);
        bus_rd(8'd5, d);
        check("R11 read right after write", d, 32'h1);
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        fuse_dis = '0; pwr_gate = '0;
        m_mc = 1'b1; m_grp = '0; m_inst = '0;
        for (int u = 0; u < 16; u++)
            for (int k = 0; k < 4; k++) model[u][k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sel_layout();
        t_mcast();
        t_unicast();
        t_term_read();
        t_term_write();
        t_mcast_skip();
        t_out_of_range();
        t_unmapped();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule